// File: doc/BRIEF.md
# Four-Bank Interrupt Flag and Mask Controller

This block gathers sixteen peripheral event lines into four banks of four sources each. Every bank keeps a 4-bit pending-flag register and a 4-bit mask-enable register. Each bank drives one CPU interrupt level output. Bank 0 feeds level 3, bank 1 feeds level 4, bank 2 feeds level 5 and bank 3 feeds level 6. A bank's level is raised whenever one of its flagged sources is also enabled.

A rising edge on an event line latches the matching flag, whatever the enable state. Software reaches the registers through a byte-wide port with an address and separate read and write strobes.

- **Clearing a flag:** software writes a one to its bit.
- **Changing enables:** software writes a byte to the enable register. The top bit of that byte chooses whether the ones in the low nibble turn enables on or off.
- **Start-up:** writing 0x0F to both registers of every bank returns the block to a quiet state.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every flag and every enable reads as zero and all four level outputs are low.
- R2: Bank i (i = 0..3) has its flag register at byte address 0x30 + 0x10*i and its enable register at 0x38 + 0x10*i. A read with `bus_rd` high returns the register in bits 3:0 with bits 7:4 zero, in the same cycle.
- R3: A write to an enable register with data bit 7 = 1 sets each enable whose data bit in 3:0 is one. With bit 7 = 0 it clears each such enable. Enables whose data bit is zero keep their value, and data bits 6:4 have no effect. The new value is visible after the clock edge that takes the write.
- R4: A write to a flag register clears each flag whose data bit in 3:0 is one and leaves the others unchanged.
- R5: Event line `evt_in[4*i+j]` going from low to high sets flag j of bank i at the next clock edge, whatever the enable. A line that stays high does not set the flag again after it has been cleared.
- R6: When a rising event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: `irq_lvl[i]` is high exactly when bank i has a bit that is both flagged and enabled. Bit i of the output is CPU level i+3. The output follows the registers with no added delay.
- R8: Reads of any unmapped address return zero, writes to unmapped addresses change no register, and `bus_rdata` is zero while `bus_rd` is low.
- R9: Writing 0x0F to the enable and then the flag register of every bank leaves all flags and enables zero and all levels low, from any prior state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| evt_in | input | 16 | Event lines; bits 4i+3..4i belong to bank i |
| irq_lvl | output | 4 | Interrupt level requests; bit i is CPU level i+3 |

## Verification
The hardest case to reach from the ports is a rising event and a clearing write landing on the same flag in the same clock cycle. To provoke it, the bench raises the event line and drives the clearing write together on one falling edge, for every bit of every bank. A second hard case is a clear while an event line is still held high. The bench latches a flag, keeps the line up, clears it, and then reads back to confirm that no new edge was seen. Enable writes are swept over all 256 data values in every bank, and the whole address space is read back against a computed map.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NBANK     = 4;
  localparam int unsigned NSRC      = 4;
  localparam int unsigned SET_BIT   = 7;
  localparam int unsigned BANK_BASE = 'h30;
  localparam int unsigned STRIDE    = 'h10;
  localparam int unsigned ENA_OFS   = 'h08;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_FLAG = 2'd1,
    WK_ENA  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/irqb_addr_dec.sv
module irqb_addr_dec #(
  parameter int unsigned ADDR_W    = irqb_pkg::ADDR_W,
  parameter int unsigned NBANK     = irqb_pkg::NBANK,
  parameter int unsigned BANK_BASE = irqb_pkg::BANK_BASE,
  parameter int unsigned STRIDE    = irqb_pkg::STRIDE,
  parameter int unsigned ENA_OFS   = irqb_pkg::ENA_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [NBANK-1:0]  flag_sel,
  output logic [NBANK-1:0]  ena_sel
);
  for (genvar g = 0; g < NBANK; g++) begin : g_sel
    localparam int unsigned FLAG_A = BANK_BASE + g * STRIDE;
    localparam int unsigned ENA_A  = FLAG_A + ENA_OFS;
    assign flag_sel[g] = (addr == FLAG_A[ADDR_W-1:0]);
    assign ena_sel[g]  = (addr == ENA_A[ADDR_W-1:0]);
  end

  // R2: one register at most is selected by any address
  p_one_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_sel, ena_sel}));
endmodule

// File: rtl/irqb_bank.sv
module irqb_bank #(
  parameter int unsigned NSRC = irqb_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  irqb_pkg::wr_kind_e wkind,
  input  logic            set_op,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] flag,
  output logic [NSRC-1:0] ena,
  output logic            irq
);
  logic [NSRC-1:0] evt_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] flag_q, flag_d;
  logic [NSRC-1:0] ena_q, ena_d;
  logic [NSRC-1:0] clr_m;
  logic            flag_ce, ena_ce;

  always_comb begin
    rise    = evt & ~evt_q;
    clr_m   = (wkind == irqb_pkg::WK_FLAG) ? wbits : '0;
    flag_d  = (flag_q & ~clr_m) | rise;
    flag_ce = (wkind == irqb_pkg::WK_FLAG) | (|rise);
    ena_ce  = (wkind == irqb_pkg::WK_ENA);
    ena_d   = set_op ? (ena_q | wbits) : (ena_q & ~wbits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      flag_q <= '0;
      ena_q  <= '0;
    end else begin
      evt_q <= evt;
      if (flag_ce) flag_q <= flag_d;
      if (ena_ce)  ena_q  <= ena_d;
    end
  end

  assign flag = flag_q;
  assign ena  = ena_q;
  assign irq  = |(flag_q & ena_q);

  // R5 and R6: a rising event always leaves its flag set
  p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((flag_q & $past(rise)) == $past(rise)));
  // R4: written ones clear their flags unless an event arrived
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wkind == irqb_pkg::WK_FLAG) |=> ((flag_q & $past(wbits & ~rise)) == '0));
  // R4: without a write or an event the flags hold
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wkind != irqb_pkg::WK_FLAG) && !(|rise)) |=> $stable(flag_q));
  // R3: a set write turns on the selected enables
  p_ena_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wkind == irqb_pkg::WK_ENA) && set_op) |=> ((ena_q & $past(wbits)) == $past(wbits)));
  // R3: a clear write turns off the selected enables
  p_ena_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wkind == irqb_pkg::WK_ENA) && !set_op) |=> ((ena_q & $past(wbits)) == '0));
  // R3: unselected enables keep their value
  p_ena_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wkind == irqb_pkg::WK_ENA) |=> ((ena_q & ~$past(wbits)) == ($past(ena_q) & ~$past(wbits))));
  // R3: without an enable write the enables hold
  p_ena_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wkind != irqb_pkg::WK_ENA) |=> $stable(ena_q));
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int unsigned ADDR_W    = irqb_pkg::ADDR_W,
  parameter int unsigned DATA_W    = irqb_pkg::DATA_W,
  parameter int unsigned NBANK     = irqb_pkg::NBANK,
  parameter int unsigned NSRC      = irqb_pkg::NSRC,
  parameter int unsigned SET_BIT   = irqb_pkg::SET_BIT,
  parameter int unsigned BANK_BASE = irqb_pkg::BANK_BASE,
  parameter int unsigned STRIDE    = irqb_pkg::STRIDE,
  parameter int unsigned ENA_OFS   = irqb_pkg::ENA_OFS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NBANK*NSRC-1:0]  evt_in,
  output logic [NBANK-1:0]       irq_lvl
);
  logic [NBANK-1:0] flag_sel, ena_sel;
  logic [NSRC-1:0]  flag_v [NBANK];
  logic [NSRC-1:0]  ena_v  [NBANK];
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata[SET_BIT-1:NSRC];

  irqb_addr_dec #(
    .ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_BASE(BANK_BASE),
    .STRIDE(STRIDE), .ENA_OFS(ENA_OFS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .flag_sel(flag_sel), .ena_sel(ena_sel)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    irqb_pkg::wr_kind_e wk;
    always_comb begin
      if (bus_wr && flag_sel[g])     wk = irqb_pkg::WK_FLAG;
      else if (bus_wr && ena_sel[g]) wk = irqb_pkg::WK_ENA;
      else                           wk = irqb_pkg::WK_NONE;
    end

    irqb_bank #(.NSRC(NSRC)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .evt(evt_in[g*NSRC +: NSRC]),
      .wkind(wk),
      .set_op(bus_wdata[SET_BIT]),
      .wbits(bus_wdata[NSRC-1:0]),
      .flag(flag_v[g]), .ena(ena_v[g]),
      .irq(irq_lvl[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      for (int i = 0; i < NBANK; i++) begin
        if (flag_sel[i]) bus_rdata = DATA_W'(flag_v[i]);
        if (ena_sel[i])  bus_rdata = DATA_W'(ena_v[i]);
      end
    end
  end

  // R8: the read port is quiet without a read strobe
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
  // R2: the upper data bits never carry register content
  p_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NSRC] == '0);
endmodule

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] evt_in = '0;
  logic [3:0]  irq_lvl;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [3:0] m_flag [4];
  logic [3:0] m_ena  [4];

  always #10 clk = ~clk;

  irq_bank_ctrl u_irq_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq_lvl(irq_lvl)
  );

  function automatic logic [7:0] flag_addr(input int b);
    return 8'(8'h30 + 8'h10 * b);
  endfunction
  function automatic logic [7:0] ena_addr(input int b);
    return 8'(8'h38 + 8'h10 * b);
  endfunction
  function automatic logic [7:0] exp_read(input int a);
    for (int b = 0; b < 4; b++) begin
      if (a == int'(flag_addr(b))) return {4'h0, m_flag[b]};
      if (a == int'(ena_addr(b)))  return {4'h0, m_ena[b]};
    end
    return 8'h00;
  endfunction
  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int b = 0; b < 4; b++) v[b] = |(m_flag[b] & m_ena[b]);
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic check_reg(input string req, input int a);
    logic [7:0] d;
    rd(8'(a), d);
    check(req, d, exp_read(a));
  endtask

  task automatic check_all(input string req);
    for (int b = 0; b < 4; b++) begin
      check_reg(req, flag_addr(b));
      check_reg(req, ena_addr(b));
    end
    check({req, " irq"}, {4'h0, irq_lvl}, {4'h0, exp_irq()});
  endtask

  task automatic pulse(input int b, input logic [3:0] p);
    @(negedge clk);
    evt_in[b*4 +: 4] = p;
    @(negedge clk);
    evt_in[b*4 +: 4] = 4'h0;
    m_flag[b] = m_flag[b] | p;
  endtask

  task automatic wr_ena(input int b, input logic [7:0] d);
    wr(ena_addr(b), d);
    if (d[7]) m_ena[b] = m_ena[b] | d[3:0];
    else      m_ena[b] = m_ena[b] & ~d[3:0];
  endtask

  task automatic wr_flag(input int b, input logic [3:0] d);
    wr(flag_addr(b), {4'h0, d});
    m_flag[b] = m_flag[b] & ~d;
  endtask

  initial begin
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin m_flag[b] = '0; m_ena[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_all("R1");

    // R2/R8: load distinct values, then sweep the whole address space
    for (int b = 0; b < 4; b++) begin
      wr_ena(b, 8'h80 | 8'(b + 1));
      pulse(b, 4'(4'hF - b));
    end
    for (int a = 0; a < 256; a++) check_reg("R2/R8 map", a);
    check("R8 quiet", bus_rdata, 8'h00);

    // R3/R7: every enable write value in every bank
    for (int b = 0; b < 4; b++) begin
      for (int v = 0; v < 256; v++) begin
        wr_ena(b, 8'(v));
        rd(ena_addr(b), d);
        check("R3 enable", d, {4'h0, m_ena[b]});
        check("R7 irq", {4'h0, irq_lvl}, {4'h0, exp_irq()});
      end
    end

    // R4/R5/R7: event patterns and clear patterns per bank
    for (int b = 0; b < 4; b++) begin
      wr_ena(b, 8'h8F);
      for (int p = 0; p < 16; p++) begin
        wr_flag(b, 4'hF);
        wr_ena(b, 8'(p));
        pulse(b, 4'(p));
        check_reg("R5 set", flag_addr(b));
        check("R7 irq", {4'h0, irq_lvl}, {4'h0, exp_irq()});
        wr_flag(b, 4'((p * 5 + 3) & 15));
        check_reg("R4 clear", flag_addr(b));
        check("R7 irq", {4'h0, irq_lvl}, {4'h0, exp_irq()});
        wr_ena(b, 8'h8F);
      end
    end

    // R5: a line held high does not set its flag again after a clear
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      evt_in[b*4 +: 4] = 4'hF;
      m_flag[b] = 4'hF;
      wr_flag(b, 4'hF);
      repeat (2) @(negedge clk);
      check_reg("R5 held line", flag_addr(b));
      evt_in[b*4 +: 4] = 4'h0;
    end

    // R6: event and clearing write in the same cycle
    for (int b = 0; b < 4; b++) begin
      for (int j = 0; j < 4; j++) begin
        wr_flag(b, 4'hF);
        @(negedge clk);
        evt_in[b*4 + j] = 1'b1;
        bus_addr = flag_addr(b); bus_wdata = 8'h0F; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        evt_in[b*4 + j] = 1'b0;
        m_flag[b] = 4'(1 << j);
        check_reg("R6 set wins", flag_addr(b));
      end
    end

    // R8: writes to unmapped addresses are ignored
    for (int b = 0; b < 4; b++) begin
      pulse(b, 4'(4'h5 << (b & 1)));
      wr_ena(b, 8'(8'h80 | (8'h3 << b % 3)));
    end
    for (int a = 0; a < 256; a++) begin
      if (exp_read(a) == 8'h00 && !((a & 8'h07) == 0 && a >= 8'h30 && a < 8'h70))
        wr(8'(a), (a & 1) ? 8'hFF : 8'h8F);
    end
    check_all("R8 unmapped write");

    // R9: initialization sequence
    for (int b = 0; b < 4; b++) begin
      wr_ena(b, 8'h0F);
      wr_flag(b, 4'hF);
    end
    check_all("R9 init");
    check("R9 irq low", {4'h0, irq_lvl}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule